// File: doc/BRIEF.md
# Register Readback Port

This block returns memory-mapped register values to an external processor over a shared, bidirectional data bus. The processor presents an address, then asserts chip select and an active-low read strobe. The block decodes the address continuously from the address lines alone, so the selected value has settled before the strobe arrives. The rising edge of the qualified read loads that value into an output register, and only this register feeds the pad drivers. Glitches from the decoder therefore never reach the shared bus.

The drivers are enabled combinationally while chip select and read are both low and write is high. They are released the moment either strobe returns high, without waiting for any internal clock edge, so a write can follow a read closely. The read path never crosses a clock domain, so a fast processor sees valid data well inside three internal clock periods. The only clocked logic is the synchronizer that carries a sticky protocol-error flag. That flag is raised when read and write are both asserted while the block is selected. Capturing written data is handled elsewhere.

Top module: `mmr_readback_port`

## Requirements
- R1: While reset is low and just after it is released, the block does not drive the bus and `protoErr` is 0.
- R2: While `busCsN`=0, `busRdN`=0 and `busWrN`=1, the bus carries register `busAddr`, i.e. bits `busAddr*DATA_W +: DATA_W` of `regValues`, as selected when the read asserted.
- R3: A change of `busAddr` during an ongoing read leaves the bus value unchanged until the read ends.
- R4: A change of `regValues` during an ongoing read leaves the bus value unchanged; the next read returns the new value.
- R5: A read of an address at or above `NUM_REGS` returns all zeros.
- R6: Chip select without read, and read without chip select, never enable the drivers.
- R7: The drivers turn off within 1 ns of the read strobe or chip select going high, with no clock edge in between, so a write can drive the bus at once.
- R8: Read data is on the bus within 1 ns of the qualified read asserting, even for a read shorter than one clock period.
- R9: While selected, read and write asserted together never enable the drivers, and `protoErr` reads 1 by the third rising clock edge after the overlap begins.
- R10: Once set, `protoErr` stays 1 until reset is asserted, and reset clears it.
- R11: A write access (chip select and write low, read high) never enables the drivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, used only for the error-flag synchronizer |
| rstN | input | 1 | Asynchronous active-low reset |
| regValues | input | NUM_REGS*DATA_W | Current values of all readable registers, register 0 in the low bits |
| busAddr | input | ADDR_W | Processor address lines |
| busCsN | input | 1 | Active-low chip select |
| busRdN | input | 1 | Active-low read strobe |
| busWrN | input | 1 | Active-low write strobe |
| busData | inout | DATA_W | Shared bidirectional data bus |
| protoErr | output | 1 | Sticky flag for a read/write overlap, in the clock domain |

## Verification
The clocked assertions assume that each strobe, once it changes, stays put for at least one clock period. Without that, two read edges could fall between samples and the output-register stability check would be meaningless. They also assume the address settles before the read strobe falls, which is the timing the decoder depends on. The bench follows both rules: it changes the address a nanosecond before asserting the strobes, and it holds every strobe level across a clock edge, except in the single short-pulse read, which starts and ends between two edges. When it expects the block to be silent, the bench drives the bus itself, with zero or with write data, so that a stray driver shows up as contention.

// File: rtl/mmr_rb_pkg.sv
package mmr_rb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic driveEn;    // qualified read: capture edge and pad enable
    logic rdWrClash;  // read and write asserted together while selected
  } rbStrobes_t;
endpackage

// File: rtl/mmr_rb_ctrl.sv
module mmr_rb_ctrl
  import mmr_rb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busCsN,
  input  logic       busRdN,
  input  logic       busWrN,
  output rbStrobes_t strobes,
  output logic       protoErr
);
  localparam int LAST = SYNC_STAGES - 1;

  logic selected;
  logic clash;
  logic errLatch;
  logic [SYNC_STAGES-1:0] errSync;

  // Purely combinational strobe qualification: no clock on the read path
  assign selected        = ~busCsN;
  assign clash           = selected & ~busRdN & ~busWrN;
  assign strobes.driveEn = selected & ~busRdN & busWrN;
  assign strobes.rdWrClash = clash;

  // The overlap itself sets the flag, so even a sub-cycle clash is kept
  always_ff @(posedge clash or negedge rstN) begin
    if (!rstN) errLatch <= 1'b0;
    else       errLatch <= 1'b1;
  end

  // Carry the flag into the clock domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errSync <= '0;
    else       errSync <= {errSync[LAST-1:0], errLatch};
  end

  assign protoErr = errSync[LAST];

  // R6: chip select high never lets the drivers on
  assert_cs_gates_R6: assert property (@(posedge clk) disable iff (!rstN)
    busCsN |-> !strobes.driveEn);

  // R9 / R11: an asserted write strobe keeps the drivers off
  assert_write_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWrN |-> !strobes.driveEn);

  // R10: the error flag never clears on its own
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(protoErr) |-> protoErr);
endmodule

// File: rtl/mmr_rb_datapath.sv
module mmr_rb_datapath
  import mmr_rb_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REGS*DATA_W-1:0] regValues,
  input  logic [ADDR_W-1:0]          busAddr,
  input  rbStrobes_t                 strobes,
  inout  wire  [DATA_W-1:0]          busData
);
  logic [DATA_W-1:0] masked [NUM_REGS];
  logic [DATA_W-1:0] selValue;
  logic [DATA_W-1:0] outReg;
  logic              capEdge;

  // One-hot address compare per register; unmapped addresses hit nothing
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    logic hit;
    assign hit       = (busAddr == ADDR_W'(i));
    assign masked[i] = hit ? regValues[i*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    selValue = '0;
    for (int i = 0; i < NUM_REGS; i++) selValue = selValue | masked[i];
  end

  // The qualified read strobe clocks the output register
  assign capEdge = strobes.driveEn;

  always_ff @(posedge capEdge or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else       outReg <= selValue;
  end

  // Pads see only the register; release is combinational
  assign busData = strobes.driveEn ? outReg : {DATA_W{1'bz}};

  // R3 / R4: the value on the pads holds for the whole read
  assert_hold_during_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.driveEn) && strobes.driveEn) |-> $stable(outReg));

  // R5: unmapped addresses decode to zero
  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) >= NUM_REGS) |-> (selValue == '0));
endmodule

// File: rtl/mmr_readback_port.sv
module mmr_readback_port
  import mmr_rb_pkg::*;
#(
  parameter int NUM_REGS    = 6,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REGS*DATA_W-1:0] regValues,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busCsN,
  input  logic                       busRdN,
  input  logic                       busWrN,
  inout  wire  [DATA_W-1:0]          busData,
  output logic                       protoErr
);
  rbStrobes_t strobes;

  mmr_rb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busCsN(busCsN), .busRdN(busRdN),
    .busWrN(busWrN), .strobes(strobes), .protoErr(protoErr)
  );

  mmr_rb_datapath #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .regValues(regValues), .busAddr(busAddr),
    .strobes(strobes), .busData(busData)
  );
endmodule

// File: tb/mmr_readback_port_tb.sv
module mmr_readback_port_tb_top;
  localparam int NUM_REGS = 6;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_REGS*DATA_W-1:0] regValues;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busCsN = 1'b1, busRdN = 1'b1, busWrN = 1'b1;
  wire  [DATA_W-1:0] busData;
  logic protoErr;

  logic benchDrive = 1'b1;
  logic [DATA_W-1:0] benchVal = '0;
  logic [DATA_W-1:0] model [NUM_REGS];
  logic [DATA_W-1:0] expBus = '0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign busData = benchDrive ? benchVal : {DATA_W{1'bz}};

  always_comb
    for (int i = 0; i < NUM_REGS; i++) regValues[i*DATA_W +: DATA_W] = model[i];

  mmr_readback_port #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .regValues(regValues), .busAddr(busAddr),
    .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN), .busData(busData),
    .protoErr(protoErr)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] refRead(input int a);
    return (a < NUM_REGS) ? model[a] : '0;
  endfunction

  // Reference model compared on every clock
  always @(negedge clk)
    if (rstN && !done) chk("R2 per-cycle bus model", busData, expBus);

  task automatic startRead(input int a);
    busAddr = ADDR_W'(a);
    #1;
    benchDrive = 1'b0;
    busCsN = 1'b0; busRdN = 1'b0;
    expBus = refRead(a);
    #1 chk("R8 data within 1 ns of read", busData, expBus);
  endtask

  task automatic endRead();
    busRdN = 1'b1; busCsN = 1'b1;
    benchDrive = 1'b1; benchVal = '0; expBus = '0;
    #1 chk("R7 released within 1 ns", busData, '0);
  endtask

  task automatic readReg(input int a, input string req);
    @(negedge clk); #0.5;
    startRead(a);
    repeat (2) @(negedge clk);
    chk(req, busData, refRead(a));
    #0.5 endRead();
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234;
    for (int i = 0; i < NUM_REGS; i++) model[i] = DATA_W'(16'h1111 * (i + 1) + 3);
    repeat (3) @(negedge clk);
    chk("R1 protoErr low in reset", {15'b0, protoErr}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 protoErr low after reset", {15'b0, protoErr}, 16'h0);
    chk("R1 bus not driven after reset", busData, '0);

    for (int a = 0; a < NUM_REGS; a++) readReg(a, "R2 selected register");
    readReg(NUM_REGS, "R5 first unmapped address");
    readReg((1 << ADDR_W) - 1, "R5 top address");

    // R3: address moves mid-read
    @(negedge clk); #0.5 startRead(2);
    @(negedge clk); busAddr = 4'd4;
    repeat (2) @(negedge clk);
    chk("R3 address change ignored", busData, model[2]);
    #0.5 endRead();

    // R4: register changes mid-read
    @(negedge clk); #0.5 startRead(1);
    @(negedge clk); model[1] = 16'hBEEF;
    repeat (2) @(negedge clk);
    chk("R4 value change ignored", busData, 16'h2225);
    #0.5 endRead();
    readReg(1, "R4 next read sees new value");

    // R6: chip select alone, then read alone (bench keeps driving zero)
    @(negedge clk); #0.5 busCsN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 chip select alone", busData, '0);
    busCsN = 1'b1; busRdN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 read alone", busData, '0);
    busRdN = 1'b1;

    // R7 + R11: read immediately followed by a write
    @(negedge clk); #0.5 startRead(3);
    @(negedge clk); #0.5;
    busRdN = 1'b1; busWrN = 1'b0;
    benchDrive = 1'b1; benchVal = 16'h5A5A; expBus = 16'h5A5A;
    #1 chk("R7 write follows read at once", busData, 16'h5A5A);
    repeat (2) @(negedge clk);
    chk("R11 write access not driven", busData, 16'h5A5A);
    chk("R11 no error on plain write", {15'b0, protoErr}, 16'h0);
    busWrN = 1'b1; busCsN = 1'b1; benchVal = '0; expBus = '0;

    // R8: read pulse shorter than a clock period, between two edges
    @(posedge clk); #0.2;
    busAddr = 4'd5; #0.5;
    benchDrive = 1'b0; busCsN = 1'b0; busRdN = 1'b0; expBus = model[5];
    #1 chk("R8 short read data", busData, model[5]);
    busRdN = 1'b1; busCsN = 1'b1; benchDrive = 1'b1; expBus = '0;
    #1 chk("R7 short read released", busData, '0);

    // Back-to-back reads with fresh register contents
    for (int n = 0; n < 20; n++) begin
      seed = seed * 1103515245 + 12345;
      model[n % NUM_REGS] = DATA_W'(seed >> 8);
      readReg((seed >>> 3) & 7, "R2 pattern read");
    end

    // R9: read and write overlap while selected
    @(negedge clk); #0.5;
    busCsN = 1'b0; busWrN = 1'b0; benchVal = 16'hC3C3; expBus = 16'hC3C3;
    #1 busRdN = 1'b0;
    #1 chk("R9 no drive during clash", busData, 16'hC3C3);
    @(negedge clk); busRdN = 1'b1;
    @(negedge clk); busWrN = 1'b1; busCsN = 1'b1; benchVal = '0; expBus = '0;
    @(negedge clk);
    chk("R9 protoErr raised", {15'b0, protoErr}, 16'h1);
    readReg(0, "R2 read after clash");
    repeat (10) @(negedge clk);
    chk("R10 protoErr sticky", {15'b0, protoErr}, 16'h1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 reset clears protoErr", {15'b0, protoErr}, 16'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 protoErr stays low after reset", {15'b0, protoErr}, 16'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule